// File: doc/BRIEF.md
# Multiplexed Bus Decoder and Demultiplexer

This block sits between an 8-bit processor and its memories and peripherals. The processor time-shares its low address byte with data on the same eight pins. The block captures that byte while the address latch enable is high and rebuilds the full 16-bit address from it. It turns the active-low read and write strobes, together with the processor's I/O-versus-memory status, into four separate selects: memory read, memory write, I/O read and I/O write.

A parameter picks how the I/O space is split off. In port-mapped mode the status line alone decides between memory and I/O, and an 8-bit port number names the device. In memory-mapped mode the status line has no effect, and address bit 15 splits the 64K space in two: memory below, I/O above. Addresses beyond the populated memory or port range select nothing. Reads from them return all ones. The block drives the returned read data back onto the shared bus only while a read is in progress. For slow ports it pulls the processor's ready input low for a fixed number of clocks, which stretches the cycle.

Top module: `mux_bus_decoder`

## Requirements
- R1: The low address byte `addr_o[7:0]` follows `ad_i` while `ale` is 1. When `ale` falls, it keeps the last byte captured on a rising clock edge with `ale` at 1, until the next `ale` pulse. `addr_o[15:8]` always equals `addr_hi_i`.
- R2: With `MEM_MAPPED`=0, a mapped access selects I/O when `io_m`=1 and memory when `io_m`=0, whatever the upper address byte holds.
- R3: With `MEM_MAPPED`=1, `io_m` has no effect: `addr_o[15]`=1 selects I/O and `addr_o[15]`=0 selects memory.
- R4: At most one of `mem_rd_o`, `mem_wr_o`, `io_rd_o` and `io_wr_o` is 1 at any time. All four are 0 when both strobes are high, and also when both strobes are low together.
- R5: `port_o` equals the latched low address byte and serves as the port number for I/O decoding.
- R6: A memory access at an address of `MEM_LIMIT` or above selects nothing. So does an I/O access at a port number of `PORT_LIMIT` or above. A read from either returns 8'hFF.
- R7: `ad_oe_o` is 1 only while `rd_n`=0 and `wr_n`=1. `ad_o` then carries `mem_rdata_i` on a memory read, `io_rdata_i` on an I/O read, and 8'hFF otherwise.
- R8: A mapped I/O access to a port of `SLOW_PORT_MIN` or above holds `ready_o` at 0 for exactly `WAIT_CYCLES` clocks. The hold starts in the cycle in which a strobe first goes low. `WAIT_CYCLES`=0 never lowers `ready_o`, and every other access leaves it at 1.
- R9: During and just after reset, `ready_o` is 1, the latched low byte is 0, and no select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch enable from the CPU |
| io_m | input | 1 | CPU status: 1 = I/O cycle, 0 = memory cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr_hi_i | input | 8 | Unmultiplexed upper address byte |
| ad_i | input | 8 | Multiplexed low address/data bus as driven by the CPU |
| mem_rdata_i | input | 8 | Read data from memory |
| io_rdata_i | input | 8 | Read data from peripherals |
| addr_o | output | 16 | Demultiplexed full address |
| port_o | output | 8 | Port number for I/O decoding |
| mem_rd_o | output | 1 | Memory read select |
| mem_wr_o | output | 1 | Memory write select |
| io_rd_o | output | 1 | I/O read select |
| io_wr_o | output | 1 | I/O write select |
| ready_o | output | 1 | Ready toward the CPU, 0 requests a wait state |
| ad_o | output | 8 | Read data returned toward the CPU bus |
| ad_oe_o | output | 1 | Output enable for `ad_o` onto the shared bus |

## Verification
On every cycle, the assertions check the following:
- At most one select is active, and none is active when the strobes are idle or conflicting.
- The low byte holds while the latch is closed.
- An I/O select agrees with the status line in port-mapped mode and with bit 15 in memory-mapped mode.
- The bus is driven only during a read, and unmapped reads show all ones.
- The ready output never rises again inside the configured wait window.

Only the bench scenarios can show the rest, because each depends on a particular address value or cycle count:
- which device an address actually reaches;
- where the memory and port limits fall;
- that the status line is ignored in memory-mapped mode;
- that a slow port stretches the cycle by exactly the configured count and a fast port not at all.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    // One-hot-or-zero strobe group presented to memories and peripherals
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } sel_t;

    localparam int unsigned LO_W   = 8;
    localparam int unsigned ADDR_W = 16;

endpackage

// File: rtl/bus_addr_latch.sv
module bus_addr_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] ad_i,
    output logic [W-1:0] lo_o
);

    typedef struct packed {
        logic [W-1:0] lat;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ale) begin
            st_d.lat = ad_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Transparent while the enable is high, holding once it drops
    assign lo_o = ale ? ad_i : st_q.lat;

    // R1: the presented low byte cannot move while the latch stays closed
    a_r1_hold_while_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> (ale || $stable(lo_o)));

endmodule

// File: rtl/bus_space_decode.sv
module bus_space_decode
    import mbd_pkg::*;
#(
    parameter bit          MEM_MAPPED    = 1'b0,
    parameter int unsigned MEM_LIMIT     = 24576,
    parameter int unsigned PORT_LIMIT    = 192,
    parameter int unsigned SLOW_PORT_MIN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              io_m,
    input  logic              rd_n,
    input  logic              wr_n,
    output sel_t              sel_o,
    output logic              rd_o,
    output logic              act_o,
    output logic              slow_o
);

    localparam logic [ADDR_W:0] MEM_LIM_X  = (ADDR_W+1)'(MEM_LIMIT);
    localparam logic [LO_W:0]   PORT_LIM_X = (LO_W+1)'(PORT_LIMIT);
    localparam logic [LO_W:0]   SLOW_MIN_X = (LO_W+1)'(SLOW_PORT_MIN);

    logic            rd_c, wr_c, is_io, hit_io, hit_mem;
    logic [LO_W-1:0] port;

    assign rd_c = !rd_n && wr_n;
    assign wr_c = !wr_n && rd_n;
    assign port = addr_i[LO_W-1:0];

    generate
        if (MEM_MAPPED) begin : g_top_bit
            assign is_io = addr_i[ADDR_W-1];
            // R3: an I/O select only ever appears in the upper half
            a_r3_io_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_o.io_rd || sel_o.io_wr) |-> addr_i[ADDR_W-1]);
        end else begin : g_status_line
            assign is_io = io_m;
            // R2: an I/O select only ever appears with the status line at I/O
            a_r2_io_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_o.io_rd || sel_o.io_wr) |-> io_m);
        end
    endgenerate

    assign hit_io  = is_io  && ({1'b0, port} < PORT_LIM_X);
    assign hit_mem = !is_io && ({1'b0, addr_i} < MEM_LIM_X);

    always_comb begin
        sel_o        = '0;
        sel_o.mem_rd = hit_mem && rd_c;
        sel_o.mem_wr = hit_mem && wr_c;
        sel_o.io_rd  = hit_io  && rd_c;
        sel_o.io_wr  = hit_io  && wr_c;
    end

    assign rd_o   = rd_c;
    assign act_o  = rd_c || wr_c;
    assign slow_o = hit_io && (rd_c || wr_c) && ({1'b0, port} >= SLOW_MIN_X);

    // R4: selects never overlap
    a_r4_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));
    // R4: nothing selected on idle or conflicting strobes
    a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n == wr_n) |-> (sel_o == '0));

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
    parameter int unsigned WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic slow_i,
    output logic ready_o
);

    localparam int unsigned CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'((WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0);
    localparam bit ENABLED = (WAIT_CYCLES > 0);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } wait_state_t;

    wait_state_t st_d, st_q;
    logic        start;

    // A new strobe toward a slow port opens the wait window
    assign start = ENABLED && slow_i && act_i && !st_q.act;

    always_comb begin
        st_d     = st_q;
        st_d.act = act_i;
        if (start) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = !(start || (st_q.cnt != '0));

    generate
        if (WAIT_CYCLES == 0) begin : g_no_wait
            // R8: no wait states are ever requested
            a_r8_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
                ready_o);
        end else if (WAIT_CYCLES >= 2) begin : g_multi_wait
            // R8: a window of two or more clocks cannot close after one
            a_r8_window_not_short: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ready_o) |=> !ready_o);
        end
    endgenerate

endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
    import mbd_pkg::*;
#(
    parameter bit          MEM_MAPPED    = 1'b0,
    parameter int unsigned MEM_LIMIT     = 24576,
    parameter int unsigned PORT_LIMIT    = 192,
    parameter int unsigned SLOW_PORT_MIN = 128,
    parameter int unsigned WAIT_CYCLES   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ale,
    input  logic        io_m,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [7:0]  addr_hi_i,
    input  logic [7:0]  ad_i,
    input  logic [7:0]  mem_rdata_i,
    input  logic [7:0]  io_rdata_i,
    output logic [15:0] addr_o,
    output logic [7:0]  port_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        io_rd_o,
    output logic        io_wr_o,
    output logic        ready_o,
    output logic [7:0]  ad_o,
    output logic        ad_oe_o
);

    logic [LO_W-1:0] lo_byte;
    sel_t            sel;
    logic            rd_c, act_c, slow_c;

    bus_addr_latch #(.W(LO_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (ale),
        .ad_i  (ad_i),
        .lo_o  (lo_byte)
    );

    assign addr_o = {addr_hi_i, lo_byte};
    assign port_o = lo_byte;

    bus_space_decode #(
        .MEM_MAPPED    (MEM_MAPPED),
        .MEM_LIMIT     (MEM_LIMIT),
        .PORT_LIMIT    (PORT_LIMIT),
        .SLOW_PORT_MIN (SLOW_PORT_MIN)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_o),
        .io_m   (io_m),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .sel_o  (sel),
        .rd_o   (rd_c),
        .act_o  (act_c),
        .slow_o (slow_c)
    );

    bus_wait_gen #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act_c),
        .slow_i  (slow_c),
        .ready_o (ready_o)
    );

    assign mem_rd_o = sel.mem_rd;
    assign mem_wr_o = sel.mem_wr;
    assign io_rd_o  = sel.io_rd;
    assign io_wr_o  = sel.io_wr;

    // Read return path: selected device, or all ones for a hole in the map
    always_comb begin
        ad_o = 8'hFF;
        if (sel.mem_rd) begin
            ad_o = mem_rdata_i;
        end else if (sel.io_rd) begin
            ad_o = io_rdata_i;
        end
    end

    assign ad_oe_o = rd_c;

    // R7: the bus is driven back only during a clean read
    a_r7_drive_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> (!rd_n && wr_n));
    // R6: a read that selected nothing returns all ones
    a_r6_unmapped_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe_o && !mem_rd_o && !io_rd_o) |-> (ad_o == 8'hFF));

endmodule

// File: tb/mux_bus_decoder_test.sv
module mux_bus_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  addr_hi = 8'h00, ad = 8'h00;
    logic [7:0]  mem_rdata = 8'hA5, io_rdata = 8'h3C;

    logic [15:0] addr_p, addr_m;
    logic [7:0]  port_p, port_m, dout_p, dout_m;
    logic        mr_p, mw_p, ir_p, iw_p, rdy_p, oe_p;
    logic        mr_m, mw_m, ir_m, iw_m, rdy_m, oe_m;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_decoder #(.MEM_MAPPED(1'b0), .WAIT_CYCLES(2)) uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi_i(addr_hi), .ad_i(ad), .mem_rdata_i(mem_rdata), .io_rdata_i(io_rdata),
        .addr_o(addr_p), .port_o(port_p), .mem_rd_o(mr_p), .mem_wr_o(mw_p),
        .io_rd_o(ir_p), .io_wr_o(iw_p), .ready_o(rdy_p), .ad_o(dout_p), .ad_oe_o(oe_p)
    );

    mux_bus_decoder #(.MEM_MAPPED(1'b1), .WAIT_CYCLES(0)) uut_mm (
        .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi_i(addr_hi), .ad_i(ad), .mem_rdata_i(mem_rdata), .io_rdata_i(io_rdata),
        .addr_o(addr_m), .port_o(port_m), .mem_rd_o(mr_m), .mem_wr_o(mw_m),
        .io_rd_o(ir_m), .io_wr_o(iw_m), .ready_o(rdy_m), .ad_o(dout_m), .ad_oe_o(oe_m)
    );

    // Select nibble order: {mem_rd, mem_wr, io_rd, io_wr}
    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
        logic       iom;
        logic       wr;
        logic [3:0] pm_sel;
        logic [3:0] mm_sel;
        logic [7:0] pm_dat;
        logic [7:0] mm_dat;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'h12, 8'h34, 1'b0, 1'b0, 4'h8, 4'h8, 8'hA5, 8'hA5},
        '{8'h12, 8'h34, 1'b1, 1'b0, 4'h2, 4'h8, 8'h3C, 8'hA5},
        '{8'h90, 8'h10, 1'b0, 1'b1, 4'h0, 4'h1, 8'h00, 8'h00},
        '{8'h90, 8'h10, 1'b1, 1'b1, 4'h1, 4'h1, 8'h00, 8'h00},
        '{8'h70, 8'h00, 1'b0, 1'b0, 4'h0, 4'h0, 8'hFF, 8'hFF},
        '{8'hFF, 8'hC5, 1'b1, 1'b0, 4'h0, 4'h0, 8'hFF, 8'hFF},
        '{8'h5F, 8'hFF, 1'b0, 1'b1, 4'h4, 4'h4, 8'h00, 8'h00},
        '{8'h80, 8'h20, 1'b0, 1'b0, 4'h0, 4'h2, 8'hFF, 8'h3C},
        '{8'h00, 8'h00, 1'b1, 1'b1, 4'h1, 4'h4, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input logic iom);
        @(negedge clk);
        ale = 1'b1; ad = lo; addr_hi = hi; io_m = iom;
        @(negedge clk);
        ale = 1'b0; ad = 8'hEE;
    endtask

    task automatic strobe(input logic wr);
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        #1;
    endtask

    task automatic release_bus();
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        #2;
        chk("R9 ready in reset", {31'd0, rdy_p}, 32'd1);
        chk("R9 selects in reset", {28'd0, mr_p, mw_p, ir_p, iw_p}, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 latched byte after reset", {16'd0, addr_p}, 32'h0000);
        chk("R9 ready after reset", {31'd0, rdy_p}, 32'd1);

        // Table walk: both decoding modes side by side
        foreach (VECS[i]) begin
            addr_phase(VECS[i].hi, VECS[i].lo, VECS[i].iom);
            strobe(VECS[i].wr);
            chk("R1 address rebuilt", {16'd0, addr_p}, {16'd0, VECS[i].hi, VECS[i].lo});
            chk("R5 port number", {24'd0, port_p}, {24'd0, VECS[i].lo});
            chk("R2 port-mapped selects", {28'd0, mr_p, mw_p, ir_p, iw_p}, {28'd0, VECS[i].pm_sel});
            chk("R3 memory-mapped selects", {28'd0, mr_m, mw_m, ir_m, iw_m}, {28'd0, VECS[i].mm_sel});
            chk("R7 drive enable", {31'd0, oe_p}, {31'd0, !VECS[i].wr});
            if (!VECS[i].wr) begin
                chk("R6 R7 port-mapped read data", {24'd0, dout_p}, {24'd0, VECS[i].pm_dat});
                chk("R6 R7 memory-mapped read data", {24'd0, dout_m}, {24'd0, VECS[i].mm_dat});
            end
            chk("R8 fast access keeps ready", {31'd0, rdy_p}, 32'd1);
            release_bus();
            #1;
            chk("R4 idle after release", {28'd0, mr_p, mw_p, ir_p, iw_p}, 32'd0);
        end

        // R1: transparency while enable is high, hold once it falls
        @(negedge clk);
        ale = 1'b1; ad = 8'h5A; addr_hi = 8'h01; #1;
        chk("R1 transparent", {24'd0, addr_p[7:0]}, 32'h5A);
        @(negedge clk);
        ad = 8'h6B; #1;
        chk("R1 follows input", {24'd0, addr_p[7:0]}, 32'h6B);
        @(negedge clk);
        ale = 1'b0; ad = 8'h00; #1;
        chk("R1 holds after fall", {24'd0, addr_p[7:0]}, 32'h6B);
        @(negedge clk);
        ad = 8'hC3; #1;
        chk("R1 still held", {24'd0, addr_p[7:0]}, 32'h6B);

        // R4: both strobes low together selects nothing and does not drive
        addr_phase(8'h10, 8'h00, 1'b0);
        rd_n = 1'b0; wr_n = 1'b0; #1;
        chk("R4 conflicting strobes", {28'd0, mr_p, mw_p, ir_p, iw_p}, 32'd0);
        chk("R7 no drive on conflict", {31'd0, oe_p}, 32'd0);
        release_bus();

        // R8: slow port stretches by exactly two clocks
        addr_phase(8'h80, 8'h90, 1'b1);
        strobe(1'b0);
        chk("R8 slow io select", {31'd0, ir_p}, 32'd1);
        chk("R8 wait clock 1", {31'd0, rdy_p}, 32'd0);
        chk("R8 zero-wait instance", {31'd0, rdy_m}, 32'd1);
        @(negedge clk); #1;
        chk("R8 wait clock 2", {31'd0, rdy_p}, 32'd0);
        @(negedge clk); #1;
        chk("R8 released", {31'd0, rdy_p}, 32'd1);
        release_bus();

        // R8: slow write behaves the same
        addr_phase(8'h00, 8'hBF, 1'b1);
        strobe(1'b1);
        chk("R8 slow write wait", {31'd0, rdy_p}, 32'd0);
        @(negedge clk); #1;
        chk("R8 slow write wait 2", {31'd0, rdy_p}, 32'd0);
        @(negedge clk); #1;
        chk("R8 slow write released", {31'd0, rdy_p}, 32'd1);
        release_bus();

        // R8: fast port just below the slow boundary never waits
        addr_phase(8'h00, 8'h7F, 1'b1);
        strobe(1'b0);
        chk("R8 fast port", {31'd0, rdy_p}, 32'd1);
        @(negedge clk); #1;
        chk("R8 fast port next clock", {31'd0, rdy_p}, 32'd1);
        release_bus();

        // R6: port just at the limit is unmapped and not slow
        addr_phase(8'h00, 8'hC0, 1'b1);
        strobe(1'b0);
        chk("R6 port limit", {28'd0, mr_p, mw_p, ir_p, iw_p}, 32'd0);
        chk("R6 port limit data", {24'd0, dout_p}, 32'hFF);
        release_bus();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule